// File: doc/BRIEF.md
# CPU Interrupt Acknowledge Interface

This block sits between an interrupt distributor and one processor core. Each cycle the distributor offers its single best pending candidate: a valid flag, an interrupt ID and a priority value, where a lower value is more urgent. The block raises an interrupt request to the core when the candidate is enabled, unmasked and more urgent than whatever the core is already servicing.

Software reaches the block through a word-addressed 32-bit register port. Reading the acknowledge register hands the candidate's ID to software. The same read makes the interrupt active: its priority is pushed onto a stack of active priorities and an acknowledge strobe goes to the distributor. If nothing is eligible, the read returns a reserved spurious ID instead. Writing the ID back to the end-of-interrupt register pops the stack, which lowers the running priority, and strobes a deactivation to the distributor. Nested preemption is therefore bounded by the stack depth.

Top module: `cpu_irq_if`

## Requirements
- R1: Bit 0 of the control word (word offset 0) enables signalling. While it is 0, `irq_o` stays low and an acknowledge read returns 1023 without changing any state.
- R2: A candidate is signalled only when its priority is strictly below the mask (word offset 1, bits 7:0). A mask of 0xFF admits every priority except 0xFF.
- R3: An acknowledge read (word offset 3) of an eligible candidate returns its ID in bits 23:0 with bits 31:24 zero. In the same cycle it pulses `ack_o` with `ack_id_o` equal to that ID, and it pushes the candidate's priority.
- R4: An acknowledge read with no eligible candidate returns 1023, does not pulse `ack_o` and leaves the running priority unchanged.
- R5: A write to the end-of-interrupt word (word offset 4) whose bits 23:0 equal the top active ID pops that entry. It pulses `eoi_o` with `eoi_id_o` equal to that ID, and the running priority reverts to the entry below.
- R6: An end-of-interrupt write whose ID does not match the top entry, or that arrives with an empty stack, is ignored: there is no `eoi_o` pulse and the running priority is unchanged.
- R7: A candidate preempts only when its priority is strictly below the current running priority.
- R8: The running priority word (word offset 5, bits 7:0) reads the top active priority, or 0xFF when nothing is active.
- R9: The pending word (word offset 6) returns the candidate ID when the candidate is valid and 1023 otherwise. Reading it has no side effect.
- R10: `irq_o` is combinational from registered state and the candidate inputs. After an acknowledge it is low in the next cycle unless a more urgent candidate appears.
- R11: The active stack holds DEPTH entries (4 by default). While it is full, no candidate is signalled.
- R12: After reset, control and mask read 0, the running priority reads 0xFF and `irq_o` is low.
- R13: Control and mask read back what was written. Writes to the read-only words (offsets 3, 5, 6) have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cand_valid_i | input | 1 | Distributor offers a candidate |
| cand_id_i | input | ID_W | Candidate interrupt ID |
| cand_prio_i | input | PRIO_W | Candidate priority, lower is more urgent |
| reg_req_i | input | 1 | Register access this cycle |
| reg_we_i | input | 1 | Access is a write |
| reg_addr_i | input | ADDR_W | Word address |
| reg_wdata_i | input | 32 | Write data |
| reg_rdata_o | output | 32 | Read data, valid in the access cycle |
| irq_o | output | 1 | Interrupt request to the core |
| ack_o | output | 1 | Acknowledge strobe to the distributor |
| ack_id_o | output | ID_W | ID being acknowledged |
| eoi_o | output | 1 | Deactivation strobe to the distributor |
| eoi_id_o | output | ID_W | ID being deactivated |

## Verification
The bench targets comparisons on the exact boundary. With the mask equal to the candidate priority, a design using a non-strict compare would raise the request. A candidate equal to the running priority must not preempt, or the core would be interrupted by its own level. It checks that a spurious acknowledge read pushes nothing; a design that pushed anyway would leave a stale 0xFF-level entry and block the next real end-of-interrupt. It also checks that a mismatched end-of-interrupt leaves the stack alone, since a careless pop would drop nesting. A full stack must silence even priority 0, because an overflow would corrupt the bottom entry.

// File: rtl/cpuif_pkg.sv
package cpuif_pkg;
  localparam int OFF_CTRL    = 0;
  localparam int OFF_MASK    = 1;
  localparam int OFF_ACK     = 3;
  localparam int OFF_EOI     = 4;
  localparam int OFF_RUN     = 5;
  localparam int OFF_PEND    = 6;
  localparam int SPURIOUS_ID = 1023;
  localparam int ID_FIELD_W  = 24;
endpackage

// File: rtl/cpuif_cfg_regs.sv
module cpuif_cfg_regs #(
  parameter int PRIO_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_ctrl_i,
  input  logic              wr_mask_i,
  input  logic [31:0]       wdata_i,
  output logic              ctrl_en_o,
  output logic [PRIO_W-1:0] mask_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctrl_en_o <= 1'b0;
      mask_o    <= '0;
    end else begin
      if (wr_ctrl_i) ctrl_en_o <= wdata_i[0];
      if (wr_mask_i) mask_o    <= wdata_i[PRIO_W-1:0];
    end
  end
endmodule

// File: rtl/cpuif_active_stack.sv
module cpuif_active_stack #(
  parameter int ID_W   = 10,
  parameter int PRIO_W = 8,
  parameter int DEPTH  = 4,
  parameter int CNT_W  = $clog2(DEPTH + 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              push_i,
  input  logic [ID_W-1:0]   push_id_i,
  input  logic [PRIO_W-1:0] push_prio_i,
  input  logic              pop_i,
  output logic [ID_W-1:0]   top_id_o,
  output logic [PRIO_W-1:0] run_prio_o,
  output logic              empty_o,
  output logic              full_o,
  output logic [CNT_W-1:0]  depth_o
);
  logic [CNT_W-1:0]  cnt_q;
  logic [ID_W-1:0]   id_q   [DEPTH];
  logic [PRIO_W-1:0] prio_q [DEPTH];

  assign empty_o = (cnt_q == '0);
  assign full_o  = (cnt_q == CNT_W'(DEPTH));
  assign depth_o = cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                  cnt_q <= '0;
    else if (push_i && !full_o)   cnt_q <= cnt_q + 1'b1;
    else if (pop_i && !empty_o)   cnt_q <= cnt_q - 1'b1;
  end

  for (genvar g = 0; g < DEPTH; g++) begin : g_slot
    localparam logic [CNT_W-1:0] SLOT = CNT_W'(g);
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        id_q[g]   <= '0;
        prio_q[g] <= '1;
      end else if (push_i && cnt_q == SLOT) begin
        id_q[g]   <= push_id_i;
        prio_q[g] <= push_prio_i;
      end
    end
  end

  always_comb begin
    top_id_o   = '0;
    run_prio_o = '1;
    for (int i = 0; i < DEPTH; i++) begin
      if (cnt_q == CNT_W'(i + 1)) begin
        top_id_o   = id_q[i];
        run_prio_o = prio_q[i];
      end
    end
  end
endmodule

// File: rtl/cpuif_select.sv
module cpuif_select #(
  parameter int PRIO_W = 8
) (
  input  logic              ctrl_en_i,
  input  logic              cand_valid_i,
  input  logic [PRIO_W-1:0] cand_prio_i,
  input  logic [PRIO_W-1:0] mask_i,
  input  logic [PRIO_W-1:0] run_prio_i,
  input  logic              full_i,
  output logic              eligible_o
);
  logic below_mask, preempts;
  assign below_mask = cand_prio_i < mask_i;
  assign preempts   = cand_prio_i < run_prio_i;
  assign eligible_o = ctrl_en_i && cand_valid_i && below_mask && preempts && !full_i;
endmodule

// File: rtl/cpu_irq_if.sv
module cpu_irq_if
  import cpuif_pkg::*;
#(
  parameter int ID_W   = 10,
  parameter int PRIO_W = 8,
  parameter int DEPTH  = 4,
  parameter int ADDR_W = 6
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cand_valid_i,
  input  logic [ID_W-1:0]   cand_id_i,
  input  logic [PRIO_W-1:0] cand_prio_i,
  input  logic              reg_req_i,
  input  logic              reg_we_i,
  input  logic [ADDR_W-1:0] reg_addr_i,
  input  logic [31:0]       reg_wdata_i,
  output logic [31:0]       reg_rdata_o,
  output logic              irq_o,
  output logic              ack_o,
  output logic [ID_W-1:0]   ack_id_o,
  output logic              eoi_o,
  output logic [ID_W-1:0]   eoi_id_o
);
  localparam int CNT_W = $clog2(DEPTH + 1);
  localparam logic [ID_W-1:0] SPUR = ID_W'(SPURIOUS_ID);

  logic              rd, wr;
  logic              wr_ctrl, wr_mask, iar_rd, eoi_wr, eoi_match;
  logic              ctrl_en, eligible, empty, full;
  logic [PRIO_W-1:0] mask, run_prio;
  logic [ID_W-1:0]   top_id, ack_val;
  logic [CNT_W-1:0]  depth;

  assign rd      = reg_req_i && !reg_we_i;
  assign wr      = reg_req_i &&  reg_we_i;
  assign wr_ctrl = wr && reg_addr_i == ADDR_W'(OFF_CTRL);
  assign wr_mask = wr && reg_addr_i == ADDR_W'(OFF_MASK);
  assign iar_rd  = rd && reg_addr_i == ADDR_W'(OFF_ACK);
  assign eoi_wr  = wr && reg_addr_i == ADDR_W'(OFF_EOI);

  // completion only retires the innermost active interrupt
  assign eoi_match = eoi_wr && !empty &&
                     reg_wdata_i[ID_FIELD_W-1:0] == ID_FIELD_W'(top_id);

  cpuif_cfg_regs #(.PRIO_W(PRIO_W)) u_cfg (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .wr_ctrl_i (wr_ctrl),
    .wr_mask_i (wr_mask),
    .wdata_i   (reg_wdata_i),
    .ctrl_en_o (ctrl_en),
    .mask_o    (mask)
  );

  cpuif_active_stack #(.ID_W(ID_W), .PRIO_W(PRIO_W), .DEPTH(DEPTH), .CNT_W(CNT_W)) u_stack (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .push_i      (ack_o),
    .push_id_i   (cand_id_i),
    .push_prio_i (cand_prio_i),
    .pop_i       (eoi_match),
    .top_id_o    (top_id),
    .run_prio_o  (run_prio),
    .empty_o     (empty),
    .full_o      (full),
    .depth_o     (depth)
  );

  cpuif_select #(.PRIO_W(PRIO_W)) u_sel (
    .ctrl_en_i    (ctrl_en),
    .cand_valid_i (cand_valid_i),
    .cand_prio_i  (cand_prio_i),
    .mask_i       (mask),
    .run_prio_i   (run_prio),
    .full_i       (full),
    .eligible_o   (eligible)
  );

  assign irq_o    = eligible;
  assign ack_o    = iar_rd && eligible;
  assign ack_id_o = cand_id_i;
  assign eoi_o    = eoi_match;
  assign eoi_id_o = top_id;
  assign ack_val  = eligible ? cand_id_i : SPUR;

  always_comb begin
    reg_rdata_o = '0;
    if (rd) begin
      unique case (reg_addr_i)
        ADDR_W'(OFF_CTRL): reg_rdata_o = {31'b0, ctrl_en};
        ADDR_W'(OFF_MASK): reg_rdata_o = 32'(mask);
        ADDR_W'(OFF_ACK):  reg_rdata_o = 32'(ack_val);
        ADDR_W'(OFF_RUN):  reg_rdata_o = 32'(run_prio);
        ADDR_W'(OFF_PEND): reg_rdata_o = 32'(cand_valid_i ? cand_id_i : SPUR);
        default:           reg_rdata_o = '0;
      endcase
    end
  end
endmodule

// File: rtl/cpu_irq_if_checker.sv
module cpu_irq_if_checker #(
  parameter int PRIO_W = 8,
  parameter int DEPTH  = 4,
  parameter int CNT_W  = 3
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              irq_o,
  input logic              ack_o,
  input logic              eoi_o,
  input logic              iar_rd,
  input logic              ctrl_en,
  input logic              cand_valid_i,
  input logic [PRIO_W-1:0] cand_prio_i,
  input logic [PRIO_W-1:0] mask,
  input logic [PRIO_W-1:0] run_prio,
  input logic [CNT_W-1:0]  depth
);
  p_disabled_quiet_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ctrl_en |-> !irq_o);
  p_mask_strict_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> (cand_valid_i && cand_prio_i < mask));
  p_ack_push_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ack_o |=> depth == $past(depth) + CNT_W'(1));
  p_spurious_still_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (iar_rd && !irq_o) |=> depth == $past(depth));
  p_eoi_pop_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    eoi_o |=> depth == $past(depth) - CNT_W'(1));
  p_preempt_strict_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> cand_prio_i < run_prio);
  p_idle_prio_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    depth == '0 |-> run_prio == '1);
  p_ack_drop_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ack_o |=> (!irq_o || cand_prio_i < $past(cand_prio_i)));
  p_full_silent_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    depth == CNT_W'(DEPTH) |-> !irq_o);
  p_no_overflow_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    depth <= CNT_W'(DEPTH));
endmodule

bind cpu_irq_if cpu_irq_if_checker #(.PRIO_W(PRIO_W), .DEPTH(DEPTH), .CNT_W(CNT_W)) u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .irq_o        (irq_o),
  .ack_o        (ack_o),
  .eoi_o        (eoi_o),
  .iar_rd       (iar_rd),
  .ctrl_en      (ctrl_en),
  .cand_valid_i (cand_valid_i),
  .cand_prio_i  (cand_prio_i),
  .mask         (mask),
  .run_prio     (run_prio),
  .depth        (depth)
);

// File: tb/cpu_irq_if_bench.sv
module cpu_irq_if_bench;
  localparam int CLK_PERIOD = 10;
  localparam int NVEC = 27;

  typedef struct packed {
    logic        we;
    logic [5:0]  addr;
    logic [31:0] wdata;
    logic        cv;
    logic [9:0]  cid;
    logic [7:0]  cpr;
    logic [31:0] exp;
    logic        eirq;
    logic [3:0]  req;
  } vec_t;

  function automatic vec_t mk(int we, int a, int d, int cv, int cid, int cpr,
                              int e, int ei, int r);
    vec_t v;
    v.we = 1'(we); v.addr = 6'(a); v.wdata = 32'(d); v.cv = 1'(cv);
    v.cid = 10'(cid); v.cpr = 8'(cpr); v.exp = 32'(e); v.eirq = 1'(ei);
    v.req = 4'(r);
    return v;
  endfunction

  // we, addr, wdata, cand_valid, cand_id, cand_prio, expected read, expected irq, tag
  localparam vec_t VEC [NVEC] = '{
    mk(0, 0, 0,     0,  0, 'h00, 0,     0, 13), // R13 ctrl reset
    mk(1, 1, 'hFF,  0,  0, 'h00, 0,     0,  2), // R2 open mask
    mk(1, 0, 1,     0,  0, 'h00, 0,     0,  1), // R1 enable
    mk(0, 1, 0,     0,  0, 'h00, 'hFF,  0, 13), // R13 mask readback
    mk(0, 6, 0,     1, 40, 'h80, 40,    1,  9), // R9 pending id
    mk(0, 5, 0,     1, 40, 'h80, 'hFF,  1,  8), // R8 idle
    mk(0, 3, 0,     1, 40, 'h80, 40,    1,  3), // R3 acknowledge
    mk(0, 5, 0,     1, 40, 'h80, 'h80,  0,  7), // R7 equal does not preempt
    mk(0, 3, 0,     1, 40, 'h80, 1023,  0,  4), // R4 spurious
    mk(0, 5, 0,     1,  7, 'h20, 'h80,  1,  7), // R7 more urgent
    mk(0, 3, 0,     1,  7, 'h20, 7,     1,  3), // R3 nested
    mk(0, 5, 0,     1,  7, 'h20, 'h20,  0,  8), // R8 top priority
    mk(1, 4, 40,    0,  0, 'h00, 0,     0,  6), // R6 mismatched eoi
    mk(0, 5, 0,     0,  0, 'h00, 'h20,  0,  6), // R6 unchanged
    mk(1, 4, 7,     0,  0, 'h00, 0,     0,  5), // R5 eoi top
    mk(0, 5, 0,     0,  0, 'h00, 'h80,  0,  5), // R5 reverts
    mk(1, 4, 40,    0,  0, 'h00, 0,     0,  5), // R5 eoi bottom
    mk(0, 5, 0,     0,  0, 'h00, 'hFF,  0,  8), // R8 idle again
    mk(0, 6, 0,     1, 55, 'hFF, 55,    0,  2), // R2 0xFF masked
    mk(0, 6, 0,     1, 55, 'hFE, 55,    1,  2), // R2 0xFE passes
    mk(1, 1, 'h80,  1, 55, 'hFE, 0,     1,  2), // R2 mask 0x80
    mk(0, 1, 0,     1, 55, 'h80, 'h80,  0,  2), // R2 equal masked
    mk(1, 0, 0,     1, 55, 'h10, 0,     1,  1), // R1 disable
    mk(0, 3, 0,     1, 55, 'h10, 1023,  0,  1), // R1 spurious when off
    mk(0, 5, 0,     1, 55, 'h10, 'hFF,  0,  4), // R4 no push
    mk(1, 5, 'h12,  0,  0, 'h00, 0,     0, 13), // R13 read-only write
    mk(0, 5, 0,     0,  0, 'h00, 'hFF,  0, 13)  // R13 unchanged
  };

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cand_valid = 1'b0;
  logic [9:0]  cand_id = '0;
  logic [7:0]  cand_prio = '0;
  logic        req = 1'b0, we = 1'b0;
  logic [5:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        irq, ack, eoi;
  logic [9:0]  ack_id, eoi_id;

  logic [31:0] s_rdata;
  logic        s_irq, s_ack, s_eoi;
  logic [9:0]  s_ack_id, s_eoi_id;
  int n_run = 0, n_fail = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  cpu_irq_if u_cpu_irq_if (
    .clk_i(clk), .rst_ni(rst_n),
    .cand_valid_i(cand_valid), .cand_id_i(cand_id), .cand_prio_i(cand_prio),
    .reg_req_i(req), .reg_we_i(we), .reg_addr_i(addr), .reg_wdata_i(wdata),
    .reg_rdata_o(rdata), .irq_o(irq), .ack_o(ack), .ack_id_o(ack_id),
    .eoi_o(eoi), .eoi_id_o(eoi_id)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic cand(input logic v, input int id, input int pr);
    cand_valid = v; cand_id = 10'(id); cand_prio = 8'(pr);
  endtask

  task automatic access(input logic w, input int a, input int d);
    @(negedge clk);
    req = 1'b1; we = w; addr = 6'(a); wdata = 32'(d);
    #1;
    s_rdata = rdata; s_irq = irq; s_ack = ack; s_ack_id = ack_id;
    s_eoi = eoi; s_eoi_id = eoi_id;
    @(posedge clk);
    #1;
    req = 1'b0; we = 1'b0;
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    cand(1'b0, 0, 0);
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
  endtask

  initial begin
    #(CLK_PERIOD * 20000);
    if (!done) begin
      n_run++; n_fail++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    do_reset();
    for (int i = 0; i < NVEC; i++) begin
      cand(VEC[i].cv, int'(VEC[i].cid), int'(VEC[i].cpr));
      access(VEC[i].we, int'(VEC[i].addr), int'(VEC[i].wdata));
      chk($sformatf("R%0d irq row %0d", VEC[i].req, i), 32'(s_irq), 32'(VEC[i].eirq));
      if (!VEC[i].we)
        chk($sformatf("R%0d data row %0d", VEC[i].req, i), s_rdata, VEC[i].exp);
    end

    // R12 reset state
    do_reset();
    #1 chk("R12 irq", 32'(irq), 32'd0);
    access(1'b0, 5, 0); chk("R12 run prio", s_rdata, 32'hFF);
    access(1'b0, 0, 0); chk("R12 ctrl", s_rdata, 32'h0);
    access(1'b0, 1, 0); chk("R12 mask", s_rdata, 32'h0);

    // R3 acknowledge strobe, R10 drop
    access(1'b1, 1, 'hFF);
    access(1'b1, 0, 1);
    cand(1'b1, 'h3FE, 'h80);
    access(1'b0, 3, 0);
    chk("R3 ack strobe", 32'(s_ack), 32'd1);
    chk("R3 ack id", 32'(s_ack_id), 32'h3FE);
    chk("R3 upper zero", s_rdata, 32'h3FE);
    @(negedge clk); #1 chk("R10 irq drops", 32'(irq), 32'd0);

    // R11 fill the stack
    cand(1'b1, 41, 'h60); access(1'b0, 3, 0);
    cand(1'b1, 42, 'h40); access(1'b0, 3, 0);
    cand(1'b1, 43, 'h20); access(1'b0, 3, 0);
    chk("R11 fourth ack", s_rdata, 32'd43);
    cand(1'b1, 44, 'h00);
    @(negedge clk); #1 chk("R11 full silent", 32'(irq), 32'd0);
    access(1'b0, 3, 0); chk("R11 full spurious", s_rdata, 32'd1023);

    // R6 mismatch, R5 strobe
    access(1'b1, 4, 42);
    chk("R6 no eoi", 32'(s_eoi), 32'd0);
    access(1'b1, 4, 43);
    chk("R5 eoi strobe", 32'(s_eoi), 32'd1);
    chk("R5 eoi id", 32'(s_eoi_id), 32'd43);
    @(negedge clk); #1 chk("R11 room again", 32'(irq), 32'd1);
    cand(1'b0, 0, 0);
    access(1'b0, 5, 0); chk("R5 run prio", s_rdata, 32'h40);

    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule